// File: doc/BRIEF.md
# Max-Tree Round-Robin Arbiter with Steered Data Select

This block picks one winner among `N` requesters in round-robin order. It also forwards the winner's data word in the same cycle. No cyclic priority search is done. Each requester is reduced to a 2-bit unsigned symbol: the request is the high bit, and a per-position priority bit is the low bit. A balanced binary tree of comparator nodes then finds the largest symbol. When two symbols tie, the node picks its right-hand side. Position 0 is the rightmost leaf, so ties resolve toward lower indices.

Each node produces a direction flag. Flag 1 means the larger symbol came from the left child, which holds higher indices. Flag 0 means it came from the right child. The same flags steer a word-wide multiplexer tree and an index tree that run in parallel with the comparison. Walking the flags from the root down gives the one-hot grant. After each grant, the priority register is reloaded with a thermometer mask that is set only for positions above the winner, so the winner drops to lowest priority.

The only stored state is the priority register. It is cleared by reset. It is loaded only when the update input is high and at least one request is present. Holding the update input low therefore keeps one requester's grant locked, for example for the length of a packet. The grant, index and data outputs are combinational from the current requests and the stored mask.

Top module: `rrmt_arbiter`

## Requirements
- R1: After reset the priority mask is all zero, so with every input requesting, position 0 is granted.
- R2: The one-hot grant `gnt_oh` has exactly one bit set, and that bit's request is active, whenever any request is active. It is all zero when no request is active.
- R3: Let the last winner be the position granted in the most recent cycle in which `upd_en` was high and a request was active. The granted position is the lowest active position above the last winner. If no active position lies above it, the grant wraps to the lowest active position. Position 0 is the rightmost, lowest index.
- R4: `gnt_idx` is the binary position of the set bit of `gnt_oh`. It is 0 when no request is active.
- R5: `data_out` equals the `DW`-bit slice `data_in[i*DW +: DW]` of the granted position `i`. It is all zero when no request is active.
- R6: While `upd_en` is low, the priority mask does not change. The same request pattern therefore keeps receiving the same grant.
- R7: A cycle with no active request leaves the priority mask unchanged, even with `upd_en` high.
- R8: Grant, index and data reflect the requests and data presented in the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the priority mask loads on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears the priority mask |
| req | input | N | Request bit per position; bit 0 is the rightmost position |
| data_in | input | N*DW | Data words packed by position: position i at [i*DW +: DW] |
| upd_en | input | 1 | When high, a grant made this cycle reloads the priority mask at the next edge |
| gnt_oh | output | N | One-hot grant |
| gnt_idx | output | $clog2(N) | Binary position of the grant |
| data_out | output | DW | Data word of the granted position, or zero when no request is active |

## Verification
Grant, index and data are combinational, so they are due in the same cycle as the stimulus. The bench changes inputs on the falling edge and samples 1 ns later, before the next rising edge. The effect of `upd_en` appears one rising edge later, as the next cycle's grant. The bench's reference model therefore advances its last-winner record only after it has sampled a cycle in which `upd_en` and a request were both high. Hold and idle scenarios confirm, on the grant port of the following cycles, that the stored priority did not move.

// File: rtl/rrmt_pkg.sv
package rrmt_pkg;

    // Symbol carried through the comparator tree: {request, priority}
    typedef logic [1:0] rrmt_sym_t;

    // Symbol values of interest
    localparam rrmt_sym_t SYM_IDLE     = 2'b00;
    localparam rrmt_sym_t SYM_REQ_LOW  = 2'b10;

    // Build a leaf symbol from a request and a priority bit
    function automatic rrmt_sym_t make_sym(input logic r, input logic p);
        return {r, p};
    endfunction

endpackage

// File: rtl/rrmt_node.sv
// One comparator node of the max tree. Right child holds the lower
// positions; on a tie the right child wins.
module rrmt_node
    import rrmt_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 3
) (
    input  rrmt_sym_t         sym_r,
    input  rrmt_sym_t         sym_l,
    input  logic [IW-1:0]     idx_r,
    input  logic [IW-1:0]     idx_l,
    input  logic [DW-1:0]     dat_r,
    input  logic [DW-1:0]     dat_l,
    output rrmt_sym_t         sym_o,
    output logic              flag_o,
    output logic [IW-1:0]     idx_o,
    output logic [DW-1:0]     dat_o
);

    always_comb begin
        flag_o = (sym_l > sym_r);
        sym_o  = flag_o ? sym_l : sym_r;
        idx_o  = flag_o ? idx_l : idx_r;
        dat_o  = flag_o ? dat_l : dat_r;
    end

endmodule

// File: rtl/rrmt_grant_decode.sv
// Walks the direction flags from the root down to form a one-hot grant.
// Node k has right child 2k and left child 2k+1; leaf N+i is position i.
module rrmt_grant_decode #(
    parameter int N = 8
) (
    input  logic         any_req,
    input  logic [N-1:1] flags,
    output logic [N-1:0] gnt
);

    logic [2*N-1:1] path_en;

    always_comb begin
        path_en    = '0;
        path_en[1] = any_req;
        for (int k = 1; k < N; k++) begin
            path_en[2*k]   = path_en[k] & ~flags[k];
            path_en[2*k+1] = path_en[k] &  flags[k];
        end
        gnt = path_en[2*N-1:N];
    end

endmodule

// File: rtl/rrmt_prio_state.sv
// Holds the thermometer priority mask: after a grant at position w, the
// mask is set for positions strictly above w.
module rrmt_prio_state #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_en,
    input  logic [N-1:0] gnt,
    output logic [N-1:0] prio_mask
);

    logic [N-1:0] mask_next;
    logic         load;

    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            mask_next[i] = seen;
            seen         = seen | gnt[i];
        end
        load = upd_en & (|gnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_mask <= '0;
        end else if (load) begin
            prio_mask <= mask_next;
        end
    end

endmodule

// File: rtl/rrmt_arbiter.sv
module rrmt_arbiter
    import rrmt_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0]             req,
    input  logic [N*DW-1:0]          data_in,
    input  logic                     upd_en,
    output logic [N-1:0]             gnt_oh,
    output logic [$clog2(N)-1:0]     gnt_idx,
    output logic [DW-1:0]            data_out
);

    localparam int IW     = $clog2(N);
    localparam int NODES  = 2 * N;

    rrmt_sym_t     sym  [1:NODES-1];
    logic [IW-1:0] idx  [1:NODES-1];
    logic [DW-1:0] dat  [1:NODES-1];
    logic [N-1:1]  flags;
    logic [N-1:0]  prio_mask;
    logic          any_req;

    // Leaves
    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign sym[N+i] = make_sym(req[i], prio_mask[i]);
        assign idx[N+i] = IW'(i);
        assign dat[N+i] = data_in[i*DW +: DW];
    end

    // Comparator nodes
    for (genvar k = 1; k < N; k++) begin : g_node
        rrmt_node #(.DW(DW), .IW(IW)) u_node (
            .sym_r  (sym[2*k]),
            .sym_l  (sym[2*k+1]),
            .idx_r  (idx[2*k]),
            .idx_l  (idx[2*k+1]),
            .dat_r  (dat[2*k]),
            .dat_l  (dat[2*k+1]),
            .sym_o  (sym[k]),
            .flag_o (flags[k]),
            .idx_o  (idx[k]),
            .dat_o  (dat[k])
        );
    end

    assign any_req = (sym[1] >= SYM_REQ_LOW);

    rrmt_grant_decode #(.N(N)) u_decode (
        .any_req (any_req),
        .flags   (flags),
        .gnt     (gnt_oh)
    );

    rrmt_prio_state #(.N(N)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_en),
        .gnt       (gnt_oh),
        .prio_mask (prio_mask)
    );

    assign gnt_idx  = any_req ? idx[1] : '0;
    assign data_out = any_req ? dat[1] : '0;

endmodule

// File: rtl/rrmt_checker.sv
module rrmt_checker #(
    parameter int N  = 8,
    parameter int DW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N-1:0]          req,
    input logic [N*DW-1:0]       data_in,
    input logic                  upd_en,
    input logic [N-1:0]          gnt_oh,
    input logic [$clog2(N)-1:0]  gnt_idx,
    input logic [DW-1:0]         data_out
);

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> ($onehot(gnt_oh) && ((gnt_oh & ~req) == '0)));

    // R2
    gnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req) |-> (gnt_oh == '0 && data_out == '0));

    // R4
    gnt_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> gnt_oh[gnt_idx]);

    // R5
    data_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (data_out == data_in[gnt_idx*DW +: DW]));

    // R6
    hold_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && $countones(req) > 0) |=> ($stable(req) -> $stable(gnt_oh)));

    // R3
    rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && $countones(req) > 1) |=> ($stable(req) -> !$stable(gnt_oh)));

endmodule

bind rrmt_arbiter rrmt_checker #(.N(N), .DW(DW)) u_rrmt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .data_in  (data_in),
    .upd_en   (upd_en),
    .gnt_oh   (gnt_oh),
    .gnt_idx  (gnt_idx),
    .data_out (data_out)
);

// File: tb/tb_rrmt_arbiter.sv
`timescale 1ns/1ps
module tb_rrmt_arbiter;

    localparam int N  = 8;
    localparam int DW = 16;
    localparam int IW = $clog2(N);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N-1:0]        req = '0;
    logic [N*DW-1:0]     data_in = '0;
    logic                upd_en = 1'b0;
    logic [N-1:0]        gnt_oh;
    logic [IW-1:0]       gnt_idx;
    logic [DW-1:0]       data_out;

    int checks = 0;
    int errors = 0;
    int last_win = -1;
    int stamp = 0;

    always #2.5 clk = ~clk;

    rrmt_arbiter #(.N(N), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .data_in(data_in),
        .upd_en(upd_en), .gnt_oh(gnt_oh), .gnt_idx(gnt_idx), .data_out(data_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int model_winner(input logic [N-1:0] r, input int lw);
        for (int i = lw + 1; i < N; i++) if (r[i]) return i;
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    function automatic logic [DW-1:0] word_of(input int i, input int s);
        return DW'(((i + 1) * 16'h1357) ^ (s * 16'h0f0f));
    endfunction

    // Drive at falling edge, sample 1 ns later, model state advances at rising edge
    task automatic step(input logic [N-1:0] r, input logic u, input string tag);
        int w;
        @(negedge clk);
        stamp++;
        req = r;
        upd_en = u;
        for (int i = 0; i < N; i++) data_in[i*DW +: DW] = word_of(i, stamp);
        #1;
        w = model_winner(r, last_win);
        if (w < 0) begin
            chk({tag, " R2 idle grant"}, 64'(gnt_oh), 64'd0);
            chk({tag, " R4 idle index"}, 64'(gnt_idx), 64'd0);
            chk({tag, " R5 idle data"}, 64'(data_out), 64'd0);
        end else begin
            chk({tag, " R3/R8 grant"}, 64'(gnt_oh), 64'(1) << w);
            chk({tag, " R4 index"}, 64'(gnt_idx), 64'(w));
            chk({tag, " R5 data"}, 64'(data_out), 64'(word_of(w, stamp)));
            if (u) last_win = w;
        end
    endtask

    task automatic t_reset();
        chk("R1 grant during reset", 64'(gnt_oh), 64'd0);
        step('1, 1'b0, "R1 first after reset");
    endtask

    task automatic t_rotate();
        for (int n = 0; n < 2 * N + 3; n++) step('1, 1'b1, "R3 rotate all");
    endtask

    task automatic t_sparse();
        step(8'b1010_0100, 1'b1, "R3 sparse a");
        step(8'b1010_0100, 1'b1, "R3 sparse b");
        step(8'b1010_0100, 1'b1, "R3 sparse c");
        step(8'b0001_0010, 1'b1, "R3 sparse d");
        step(8'b1000_0001, 1'b1, "R3 sparse e");
        step(8'b1000_0001, 1'b1, "R3 wrap");
        step(8'b0100_0000, 1'b1, "R3 single");
    endtask

    task automatic t_hold();
        for (int n = 0; n < 4; n++) step(8'b0110_1001, 1'b0, "R6 hold");
        step(8'b0110_1001, 1'b1, "R6 release");
        step(8'b0110_1001, 1'b0, "R6 moved");
        step(8'b0110_1001, 1'b0, "R6 held again");
    endtask

    task automatic t_idle();
        step('1, 1'b1, "R7 before idle");
        step('0, 1'b1, "R7 idle");
        step('0, 1'b1, "R7 idle");
        step('1, 1'b1, "R7 after idle");
    endtask

    task automatic t_same_cycle();
        step(8'b0000_1000, 1'b0, "R8 change a");
        step(8'b0001_0000, 1'b0, "R8 change b");
        step(8'b1000_0000, 1'b0, "R8 change c");
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset_pre();
        rst_n = 1'b1;
        t_reset();
        t_rotate();
        t_sparse();
        t_hold();
        t_idle();
        t_same_cycle();
        t_rotate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic t_reset_pre();
        chk("R1 reset grant idle", 64'(gnt_oh), 64'd0);
    endtask

endmodule